// File: doc/BRIEF.md
# Bus Mode Detect and Debounce Controller

This block watches a digitized sense-line voltage, given in millivolts, and sorts each sample into one of three bus modes: single-ended (SE), low-voltage differential (LVD) or high-voltage differential (HVD). Two dead bands sit between the three windows. A sample that lands in a dead band leaves the previous classification unchanged, which gives the classifier hysteresis.

A new classification becomes the committed mode only after it has stayed unchanged for a fixed number of millisecond ticks. The same count applies to every transition. The committed mode drives three registered outputs: a termination enable, a regulator enable and an LVD status flag. A disconnect request turns termination and the regulators off but never stops the mode filter. After power-good reset the block sits in SE with termination off, whatever the sense line reads.

Top module: `bus_mode_ctrl`

## Requirements
- R1: After reset the committed mode code is SE (2'b00) and termination and LVD status are low, even while the sense input reads LVD. One clock after reset is released, the regulator enable follows the disconnect input.
- R2: A sample below 500 mV is classified SE (code 2'b00). A sample above 2400 mV is classified HVD (code 2'b10). Code 2'b11 never appears.
- R3: A sample from 700 mV to 1900 mV inclusive is classified LVD (code 2'b01).
- R4: A new classification is committed only after DELAY_TICKS tick pulses have been seen while it stays unchanged. After DELAY_TICKS-1 such pulses the committed mode is still the old one.
- R5: A sample in a dead band (500..699 mV or 1901..2400 mV) keeps the previous raw classification.
- R6: If the classification changes to another non-committed mode before the count expires, the count restarts from zero for the newer mode. If it returns to the committed mode, the pending change is dropped.
- R7: The qualification delay is the same for every transition between any two modes.
- R8: With disconnect low and the committed mode SE or HVD, termination is off and the regulator enable is on.
- R9: With disconnect low and the committed mode LVD, termination, regulator enable and LVD status are all on.
- R10: With disconnect high, termination and regulator enable are off. Mode qualification continues, and LVD status still reports the committed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-good reset |
| sense_mv | input | MV_W | Sampled sense-line voltage in millivolts |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| disconnect | input | 1 | High requests termination and regulators off |
| mode_code | output | 2 | Committed mode: 00 SE, 01 LVD, 10 HVD |
| term_en | output | 1 | Termination enable |
| reg_en | output | 1 | Regulator enable |
| lvd_stat | output | 1 | High while the committed mode is LVD |

## Verification
The bench stops one tick short of the delay and checks that the old mode is still committed. A design that commits one tick early, or one tick late, fails on either side of that boundary. It then changes the candidate mode in mid-count and, separately, returns to the committed mode before the count expires. A counter that is not restarted or not cleared would commit too soon in both cases.

Samples placed exactly on the window edges and inside both dead bands expose off-by-one comparisons and a classifier that drops to a default mode instead of holding. A mode change made entirely while disconnect is high exposes a design that freezes the filter or gates LVD status along with termination.

// File: rtl/bus_mode_pkg.sv
package bus_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SE  = 2'b00,
    MODE_LVD = 2'b01,
    MODE_HVD = 2'b10
  } bus_mode_e;

  // Window classification with dead-band hold.
  function automatic bus_mode_e classify_mv(
    input int unsigned mv,
    input int unsigned se_below,
    input int unsigned lvd_lo,
    input int unsigned lvd_hi,
    input int unsigned hvd_above,
    input bus_mode_e   prev
  );
    bus_mode_e res;
    if (mv < se_below)                      res = MODE_SE;
    else if (mv > hvd_above)                res = MODE_HVD;
    else if (mv >= lvd_lo && mv <= lvd_hi)  res = MODE_LVD;
    else                                    res = prev;
    return res;
  endfunction

  function automatic logic term_allowed(input bus_mode_e m, input logic disc);
    return (m == MODE_LVD) && !disc;
  endfunction

  function automatic logic regs_allowed(input logic disc);
    return !disc;
  endfunction

endpackage

// File: rtl/sense_classifier.sv
module sense_classifier
  import bus_mode_pkg::*;
#(
  parameter int MV_W      = 12,
  parameter int SE_BELOW  = 500,
  parameter int LVD_LO    = 700,
  parameter int LVD_HI    = 1900,
  parameter int HVD_ABOVE = 2400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] sense_mv,
  output bus_mode_e       raw_mode
);

  bus_mode_e next_mode;

  always_comb begin
    next_mode = classify_mv(int'(unsigned'(sense_mv)), SE_BELOW, LVD_LO,
                            LVD_HI, HVD_ABOVE, raw_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_mode <= MODE_SE;
    else        raw_mode <= next_mode;
  end

endmodule

// File: rtl/mode_qualifier.sv
module mode_qualifier
  import bus_mode_pkg::*;
#(
  parameter int DELAY_TICKS = 190
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e raw_mode,
  input  logic      ms_tick,
  output bus_mode_e committed,
  output logic      commit_pulse,
  output logic      cand_restart
);

  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DELAY_TICKS - 1);

  bus_mode_e        cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             same_cand;

  assign differs      = (raw_mode != committed);
  assign same_cand    = (raw_mode == cand_q);
  assign cand_restart = differs && !same_cand;
  assign commit_pulse = differs && same_cand && ms_tick && (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      committed <= MODE_SE;
      cand_q    <= MODE_SE;
      cnt_q     <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (cand_restart) begin
      cand_q <= raw_mode;
      cnt_q  <= '0;
    end else if (commit_pulse) begin
      committed <= cand_q;
      cnt_q     <= '0;
    end else if (ms_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/output_gate.sv
module output_gate
  import bus_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e committed,
  input  logic      disconnect,
  output logic      term_en,
  output logic      reg_en,
  output logic      lvd_stat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_en  <= 1'b0;
      reg_en   <= 1'b0;
      lvd_stat <= 1'b0;
    end else begin
      term_en  <= term_allowed(committed, disconnect);
      reg_en   <= regs_allowed(disconnect);
      lvd_stat <= (committed == MODE_LVD);
    end
  end

endmodule

// File: rtl/bus_mode_ctrl.sv
module bus_mode_ctrl
  import bus_mode_pkg::*;
#(
  parameter int MV_W        = 12,
  parameter int SE_BELOW    = 500,
  parameter int LVD_LO      = 700,
  parameter int LVD_HI      = 1900,
  parameter int HVD_ABOVE   = 2400,
  parameter int DELAY_TICKS = 190
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] sense_mv,
  input  logic            ms_tick,
  input  logic            disconnect,
  output logic [1:0]      mode_code,
  output logic            term_en,
  output logic            reg_en,
  output logic            lvd_stat
);

  bus_mode_e raw_mode;
  bus_mode_e committed;
  logic      commit_pulse;
  logic      cand_restart;

  sense_classifier #(
    .MV_W(MV_W), .SE_BELOW(SE_BELOW), .LVD_LO(LVD_LO),
    .LVD_HI(LVD_HI), .HVD_ABOVE(HVD_ABOVE)
  ) i_class (
    .clk(clk), .rst_n(rst_n), .sense_mv(sense_mv), .raw_mode(raw_mode)
  );

  mode_qualifier #(.DELAY_TICKS(DELAY_TICKS)) i_qual (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .ms_tick(ms_tick),
    .committed(committed), .commit_pulse(commit_pulse),
    .cand_restart(cand_restart)
  );

  output_gate i_gate (
    .clk(clk), .rst_n(rst_n), .committed(committed), .disconnect(disconnect),
    .term_en(term_en), .reg_en(reg_en), .lvd_stat(lvd_stat)
  );

  assign mode_code = committed;

endmodule

// File: rtl/bus_mode_chk.sv
module bus_mode_chk #(
  parameter int MV_W      = 12,
  parameter int SE_BELOW  = 500,
  parameter int LVD_LO    = 700,
  parameter int LVD_HI    = 1900,
  parameter int HVD_ABOVE = 2400
) (
  input logic            clk,
  input logic            rst_n,
  input logic [MV_W-1:0] sense_mv,
  input logic            ms_tick,
  input logic            disconnect,
  input logic [1:0]      mode_code,
  input logic            term_en,
  input logic            reg_en,
  input logic            lvd_stat,
  input logic [1:0]      raw_code,
  input logic            commit_pulse,
  input logic            cand_restart
);

  logic armed_q;
  logic in_dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign in_dead = (int'(unsigned'(sense_mv)) >= SE_BELOW && int'(unsigned'(sense_mv)) < LVD_LO) ||
                   (int'(unsigned'(sense_mv)) > LVD_HI && int'(unsigned'(sense_mv)) <= HVD_ABOVE);

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code != 2'b11 && raw_code != 2'b11); // R2

  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && (mode_code != $past(mode_code)) |-> $past(ms_tick)); // R4

  AST_COMMIT_TAKES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> (mode_code == $past(raw_code))); // R4

  AST_NO_COMMIT_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cand_restart |-> !commit_pulse); // R6

  AST_DEAD_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(in_dead) |-> raw_code == $past(raw_code)); // R5

  AST_TERM_NEEDS_LVD: assert property (@(posedge clk) disable iff (!rst_n)
    term_en |-> lvd_stat); // R9

  AST_DISC_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(disconnect) |-> (!term_en && !reg_en)); // R10

  AST_REG_ON_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(disconnect) |-> reg_en); // R8

endmodule

bind bus_mode_ctrl bus_mode_chk #(
  .MV_W(MV_W), .SE_BELOW(SE_BELOW), .LVD_LO(LVD_LO),
  .LVD_HI(LVD_HI), .HVD_ABOVE(HVD_ABOVE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sense_mv(sense_mv), .ms_tick(ms_tick),
  .disconnect(disconnect), .mode_code(mode_code), .term_en(term_en),
  .reg_en(reg_en), .lvd_stat(lvd_stat), .raw_code(raw_mode),
  .commit_pulse(commit_pulse), .cand_restart(cand_restart)
);

// File: tb/test_bus_mode_ctrl.sv
module test_bus_mode_ctrl;

  localparam int DLY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sense_mv = 12'd1200;
  logic        ms_tick = 1'b0;
  logic        disconnect = 1'b0;
  logic [1:0]  mode_code;
  logic        term_en, reg_en, lvd_stat;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  bus_mode_ctrl #(.DELAY_TICKS(DLY)) i_bus_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sense_mv(sense_mv), .ms_tick(ms_tick),
    .disconnect(disconnect), .mode_code(mode_code), .term_en(term_en),
    .reg_en(reg_en), .lvd_stat(lvd_stat)
  );

  // mv, disc, mode, term, reg, lvd
  localparam logic [17:0] VEC [12] = '{
    {12'd1200, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1},
    {12'd2600, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0},
    {12'd100,  1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {12'd650,  1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {12'd1900, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1},
    {12'd2100, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1},
    {12'd2401, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
    {12'd1000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
    {12'd1000, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1},
    {12'd499,  1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {12'd700,  1'b0, 2'd1, 1'b1, 1'b1, 1'b1},
    {12'd500,  1'b0, 2'd1, 1'b1, 1'b1, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1'b1;
      step(1);
      ms_tick = 1'b0;
      step(1);
    end
    step(3);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input int mv, input logic disc);
    sense_mv = 12'(mv);
    disconnect = disc;
    step(3);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1: reset state with LVD on the sense line
    chk("R1 mode", mode_code, 0);
    chk("R1 term", term_en, 0);
    chk("R1 lvd", lvd_stat, 0);
    chk("R1 reg", reg_en, 1);
    // R4: one tick short, then exactly the delay
    ticks(DLY - 1);
    chk("R4 early", mode_code, 0);
    ticks(1);
    chk("R4 commit", mode_code, 1);

    // Table walk: R2 R3 R5 R7 R8 R9 R10
    for (int i = 0; i < 12; i++) begin
      apply(int'(VEC[i][17:6]), VEC[i][5]);
      ticks(DLY);
      chk($sformatf("R2/R3/R5/R7 vec%0d mode", i), mode_code, int'(VEC[i][4:3]));
      chk($sformatf("R8/R9/R10 vec%0d term", i), term_en, int'(VEC[i][2]));
      chk($sformatf("R8/R10 vec%0d reg", i), reg_en, int'(VEC[i][1]));
      chk($sformatf("R9/R10 vec%0d lvd", i), lvd_stat, int'(VEC[i][0]));
    end

    // R6: candidate changes mid-count, counter restarts (committed LVD)
    apply(2600, 1'b0);
    ticks(DLY - 1);
    apply(100, 1'b0);
    ticks(DLY - 1);
    chk("R6 restart hold", mode_code, 1);
    ticks(1);
    chk("R6 restart commit", mode_code, 0);

    // R6: return to committed cancels pending change
    apply(1200, 1'b0);
    ticks(DLY - 1);
    apply(100, 1'b0);
    ticks(2);
    apply(1200, 1'b0);
    ticks(DLY - 1);
    chk("R6 cancel hold", mode_code, 0);
    ticks(1);
    chk("R6 cancel commit", mode_code, 1);

    // R7: direct SE<-HVD path uses the same delay
    apply(3000, 1'b0);
    ticks(DLY);
    apply(200, 1'b0);
    ticks(DLY - 1);
    chk("R7 hvd->se early", mode_code, 2);
    ticks(1);
    chk("R7 hvd->se commit", mode_code, 0);

    // R10: disconnect asserted mid-qualification, filter keeps counting
    apply(1500, 1'b0);
    ticks(2);
    apply(1500, 1'b1);
    ticks(DLY - 2);
    chk("R10 mode under disc", mode_code, 1);
    chk("R10 lvd under disc", lvd_stat, 1);
    chk("R10 term under disc", term_en, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule